// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces a periodic interrupt from a time-base clock. A free-running binary divider counts edges of that clock. A 4-bit rate code chooses the divider stage whose wrap produces a one-cycle pulse. A 3-bit time-base code does two jobs. It tells the block which crystal frequency is assumed, which changes the meaning of the two fastest rate codes. It can also hold the divider at zero.

Every pulse sets a sticky periodic flag, and an acknowledge input clears it. The interrupt request output is high while the flag is set and the enable input is high. Register access and the calendar logic sit outside this block. Only the rate code, the time-base code, the enable and the flag acknowledge reach it, as plain signals.

Top module: `periodic_rate_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with `div_sel` at a hold code, `tick`, `per_flag` and `irq` are all 0.
- R2: Rate code 0 on `rate_sel` produces no `tick` pulse at any time-base code.
- R3: With `div_sel` equal to 0 (4 MHz base) or 1 (1 MHz base), rate code c in 1..15 gives `tick` pulses spaced exactly 2^c clock cycles apart. Code 15 therefore has the longest period and code 1 the shortest.
- R4: With `div_sel` equal to 2 (32 kHz base), codes 3..15 keep the spacing 2^c. Code 1 gives a spacing of 256 cycles and code 2 gives 512, the same as codes 8 and 9.
- R5: Codes 3 to 7 on `div_sel` hold the divider at zero, and no `tick` pulse occurs while one of them is applied.
- R6: When `div_sel` changes from a hold code to a running code, the first `tick` comes after exactly one full period of the selected rate, counting rising edges from the first edge at which the running code is applied. Each `tick` is high for exactly one cycle.
- R7: After a change of the rate code while the divider runs, the next `tick` comes no later than one new period. From then on, pulses are spaced by the new period.
- R8: `per_flag` goes to 1 in the cycle after a `tick` and stays there until a cycle with `flag_clr` high and `tick` low. A `tick` and `flag_clr` in the same cycle leave the flag set.
- R9: `irq` is 1 exactly when `per_flag` is 1 and `pie_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock driving the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 4 | Periodic rate code (0 disables) |
| div_sel | input | 3 | Time-base code: 0, 1, 2 run; 3 to 7 hold the divider |
| pie_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Acknowledge that clears the periodic flag |
| tick | output | 1 | One-cycle periodic pulse |
| per_flag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Interrupt request |

## Verification
Every nonzero rate code is swept under the 4 MHz base and under the 32 kHz base. The divider is released from hold for each code, so the measured delay to the first pulse tells apart the codes whose tap depends on the base from those whose tap does not. Pulse-to-pulse spacing is also measured for the faster codes, which separates a correct period from an off-by-one wrap. Code 0 and several hold codes are then run for long windows to show that no pulse appears. A mid-run rate change, combined with acknowledge and enable patterns, checks the realignment bound, the precedence of set over clear on the flag, and the gating of the request.

// File: rtl/prg_pkg.sv
package prg_pkg;

   localparam int unsigned RATE_W = 4;
   localparam int unsigned DIV_W  = 3;

   // time-base codes that let the divider run
   localparam logic [DIV_W-1:0] BASE_4M  = 3'd0;
   localparam logic [DIV_W-1:0] BASE_1M  = 3'd1;
   localparam logic [DIV_W-1:0] BASE_32K = 3'd2;

   function automatic logic base_runs(input logic [DIV_W-1:0] code);
      return (code == BASE_4M) || (code == BASE_1M) || (code == BASE_32K);
   endfunction

   function automatic logic base_is_slow(input logic [DIV_W-1:0] code);
      return code == BASE_32K;
   endfunction

endpackage

// File: rtl/prg_divider.sv
module prg_divider #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/prg_tap_sel.sv
module prg_tap_sel #(
   parameter int unsigned CNT_W     = 15,
   parameter int unsigned RATE_W    = 4,
   parameter int unsigned REMAP_OFF = 7
) (
   input  logic [CNT_W-1:0]  cnt,
   input  logic [RATE_W-1:0] rate,
   input  logic              slow,
   input  logic              run,
   output logic              pulse_d
);

   localparam int unsigned TAP_W = $clog2(CNT_W + 1);

   // match[k]: low k bits of the counter are all ones (the wrap of stage k-1)
   logic [CNT_W:0]   match;
   logic [TAP_W-1:0] eff;

   assign match[0] = 1'b0;

   generate
      for (genvar k = 1; k <= CNT_W; k++) begin : g_match
         assign match[k] = &cnt[k-1:0];
      end
   endgenerate

   always_comb begin
      if (slow && (rate == RATE_W'(1) || rate == RATE_W'(2))) begin
         eff = TAP_W'(rate) + TAP_W'(REMAP_OFF);
      end else begin
         eff = TAP_W'(rate);
      end
   end

   assign pulse_d = run && match[eff];

endmodule

// File: rtl/prg_flag.sv
module prg_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_d,
   input  logic flag_clr,
   input  logic pie_en,
   output logic tick,
   output logic per_flag,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick     <= 1'b0;
         per_flag <= 1'b0;
      end else begin
         tick     <= pulse_d;
         per_flag <= tick | (per_flag & ~flag_clr);
      end
   end

   assign irq = per_flag & pie_en;

endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen #(
   parameter int unsigned CNT_W     = 15,
   parameter int unsigned REMAP_OFF = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] rate_sel,
   input  logic [2:0] div_sel,
   input  logic       pie_en,
   input  logic       flag_clr,
   output logic       tick,
   output logic       per_flag,
   output logic       irq
);

   import prg_pkg::*;

   localparam int unsigned MAX_CODE = (1 << RATE_W) - 1;

   generate
      if (CNT_W < MAX_CODE) begin : g_bad_width
         $error("CNT_W must cover the slowest rate code");
      end
      if (REMAP_OFF + 2 > CNT_W) begin : g_bad_remap
         $error("REMAP_OFF puts the slow-base taps past the counter");
      end
   endgenerate

   logic             run;
   logic             slow;
   logic [CNT_W-1:0] cnt;
   logic             pulse_d;

   assign run  = base_runs(div_sel);
   assign slow = base_is_slow(div_sel);

   prg_divider #(.CNT_W(CNT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .cnt   (cnt)
   );

   prg_tap_sel #(
      .CNT_W     (CNT_W),
      .RATE_W    (RATE_W),
      .REMAP_OFF (REMAP_OFF)
   ) u_tap (
      .cnt     (cnt),
      .rate    (rate_sel),
      .slow    (slow),
      .run     (run),
      .pulse_d (pulse_d)
   );

   prg_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_d  (pulse_d),
      .flag_clr (flag_clr),
      .pie_en   (pie_en),
      .tick     (tick),
      .per_flag (per_flag),
      .irq      (irq)
   );

endmodule

// File: rtl/periodic_rate_gen_chk.sv
module periodic_rate_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] rate_sel,
   input logic [2:0] div_sel,
   input logic       pie_en,
   input logic       flag_clr,
   input logic       tick,
   input logic       per_flag,
   input logic       irq
);

   // R2: a zero rate code yields no pulse in the following cycle
   p_no_pulse_code0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 4'd0) |=> !tick);

   // R5: a hold code yields no pulse in the following cycle
   p_no_pulse_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (div_sel > 3'd2) |=> !tick);

   // R6: pulses are one cycle wide
   p_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

   // R8: a pulse always leaves the flag set
   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> per_flag);

   // R8: acknowledge without a pulse clears the flag
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !tick) |=> !per_flag);

   // R8: the flag only rises after a pulse
   p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(per_flag) |-> $past(tick));

   // R9: request follows the enable once a pulse has set the flag
   p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (irq == pie_en));

endmodule

bind periodic_rate_gen periodic_rate_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rate_sel (rate_sel),
   .div_sel  (div_sel),
   .pie_en   (pie_en),
   .flag_clr (flag_clr),
   .tick     (tick),
   .per_flag (per_flag),
   .irq      (irq)
);

// File: tb/periodic_rate_gen_test.sv
`timescale 1ns/1ps
module periodic_rate_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] rate_sel = 4'd0;
   logic [2:0] div_sel = 3'd7;
   logic       pie_en = 1'b0;
   logic       flag_clr = 1'b0;
   logic       tick, per_flag, irq;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   periodic_rate_gen uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .div_sel  (div_sel),
      .pie_en   (pie_en),
      .flag_clr (flag_clr),
      .tick     (tick),
      .per_flag (per_flag),
      .irq      (irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // edges from now until tick is seen at a negedge
   task automatic wait_tick(output int n, input int limit);
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end while (!tick && n < limit);
   endtask

   function automatic int period_of(input int code, input int base);
      if (base == 2 && (code == 1 || code == 2)) return 1 << (code + 7);
      return 1 << code;
   endfunction

   task automatic measure(input int code, input int base, input string req);
      int n;
      int p;
      p = period_of(code, base);
      @(negedge clk);
      div_sel  = 3'd7;
      rate_sel = 4'(code);
      @(negedge clk);
      @(negedge clk);
      div_sel = 3'(base);
      wait_tick(n, p + 4);
      check({req, "/R6 first"}, n, p);
      @(negedge clk);
      check("R6 width", int'(tick), 0);
      if (p <= 1024) begin
         wait_tick(n, p + 4);
         check({req, " spacing"}, n + 1, p);
      end
   endtask

   task automatic quiet(input int cyc, input string req);
      int seen;
      seen = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (tick) seen++;
      end
      check(req, seen, 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      int n;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 tick", int'(tick), 0);
      check("R1 flag", int'(per_flag), 0);
      check("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 tick after release", int'(tick), 0);

      // R3: 4 MHz base, every nonzero code
      for (int c = 1; c <= 15; c++) measure(c, 0, "R3");
      // R4: 32 kHz base, every nonzero code
      for (int c = 1; c <= 15; c++) measure(c, 2, "R4");
      // R3: 1 MHz base, a few codes
      measure(1, 1, "R3");
      measure(2, 1, "R3");
      measure(7, 1, "R3");

      // R2: code 0 never pulses
      rate_sel = 4'd0;
      div_sel  = 3'd0;
      quiet(600, "R2 base0");
      div_sel = 3'd2;
      quiet(600, "R2 base2");

      // R5: hold codes never pulse
      rate_sel = 4'd1;
      for (int d = 3; d <= 7; d++) begin
         div_sel = 3'(d);
         quiet(200, "R5 hold");
      end

      // R7: rate change mid-run
      measure(6, 0, "R7 setup");
      repeat (10) @(negedge clk);
      rate_sel = 4'd3;
      wait_tick(n, 20);
      checks++;
      if (n < 1 || n > 8) begin
         fails++;
         $display("FAIL R7 realign: actual %0d expected 1..8", n);
      end
      wait_tick(n, 20);
      check("R7 new spacing", n, 8);
      wait_tick(n, 20);
      check("R7 new spacing again", n, 8);

      // R8/R9: flag and request
      rate_sel = 4'd5;
      pie_en   = 1'b1;
      flag_clr = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R8 cleared", int'(per_flag), 0);
      flag_clr = 1'b0;
      wait_tick(n, 40);
      @(negedge clk);
      check("R8 set after tick", int'(per_flag), 1);
      check("R9 irq enabled", int'(irq), 1);
      pie_en = 1'b0;
      #0.1;
      check("R9 irq gated", int'(irq), 0);
      repeat (5) @(negedge clk);
      check("R8 flag sticky", int'(per_flag), 1);
      flag_clr = 1'b1;
      @(negedge clk);
      check("R8 ack clears", int'(per_flag), 0);
      // ack held high across a pulse: set wins
      wait_tick(n, 40);
      @(negedge clk);
      check("R8 set beats clear", int'(per_flag), 1);
      @(negedge clk);
      check("R8 clear next cycle", int'(per_flag), 0);
      flag_clr = 1'b0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule